// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This unit picks the larger or the smaller of two IEEE-754 operands. A parameter chooses the encoding: binary32 (8 exponent bits, 23 fraction bits) or binary64 (11 exponent bits, 52 fraction bits). Each operand is first sorted into a class: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. A fixed ladder of special-case rules is then applied. When no special case matches, the operands are ordered by sign and then by magnitude.

The unit returns one of the two operands, possibly with its quiet bit set, or a default quiet NaN. It also returns two status bits. One reports an invalid signalling-NaN input. The other reports an invalid pair of infinities that have the same sign. A caller presents `in_valid` with the operands and the operation select. The registered result, the status bits and `out_valid` appear on the next clock edge.

Top module: `fpmm_unit`

## Requirements
- R1: If operand `a` is a signalling NaN, the result is `a` with its quiet bit set, and `invalid_snan` is 1. This holds whatever `b` is. A signalling NaN has an all-ones exponent, a clear fraction MSB and a nonzero fraction. The quiet bit is the fraction MSB (bit 22 for binary32).
- R2: If `a` is not a signalling NaN and `b` is one, the result is `b` with its quiet bit set, and `invalid_snan` is 1.
- R3: If neither operand is a signalling NaN, a quiet NaN in `a` is returned unchanged. Only when `a` is not a NaN is a quiet NaN in `b` returned unchanged. A quiet NaN has an all-ones exponent and a set fraction MSB. Both status bits stay 0.
- R4: Two infinities of the same sign give the default quiet NaN, and `invalid_inf` is 1. This applies to both max and min. The default quiet NaN is positive, has an all-ones exponent and has only the quiet bit set in the fraction (0x7FC00000 for binary32).
- R5: When exactly one operand is infinite, or the two infinities differ in sign: max (`op_sel`=0) returns +inf if present and otherwise the finite operand. Min (`op_sel`=1) returns -inf if present and otherwise the other operand.
- R6: For finite operands of different sign, max returns the positive one and min returns the negative one. So max(+0, -0) is +0.
- R7: For finite operands of equal sign, magnitudes are compared by exponent and then by fraction, subnormals included. Max returns the operand of greater value and min the operand of smaller value. When the magnitudes are equal, the operands are identical and either one is returned.
- R8: `out_valid` equals the value of `in_valid` one clock earlier. A result is registered only when `in_valid` is 1. Reset sets `out_valid`, `result` and both status bits to 0.
- R9: In a cycle that follows one with `in_valid`=0, `result` keeps its previous value and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 1 | 0 selects max, 1 selects min |
| a | input | W | Left operand (W = 32 or 64) |
| b | input | W | Right operand |
| out_valid | output | 1 | Registered result is valid |
| result | output | W | Selected operand or default quiet NaN |
| invalid_snan | output | 1 | A signalling NaN was among the inputs |
| invalid_inf | output | 1 | Same-signed infinities were compared |

## Verification
The binary32 configuration is swept over every ordered pair drawn from a set of twenty values, with both max and min. The set holds both zeros, small and large subnormals, normals that share an exponent but differ in fraction, the largest finite values, both infinities, quiet NaNs with payloads and signalling NaNs with payloads. Pairs of two NaNs tell apart the left-before-right priority and the quieting. Pairs of two infinities separate the invalid case from the ordered case. ±0 and the same-exponent normals tell a sign decision apart from a magnitude decision. An idle cycle after a valid one shows that the result is held and the status bits are cleared.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0]   operand,
  output fp_class_e               cls,
  output logic                    sign,
  output logic [EXP_W+FRAC_W-1:0] mag
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  assign sign = operand[W-1];
  assign mag  = operand[W-2:0];
  assign expo = operand[W-2:FRAC_W];
  assign frac = operand[FRAC_W-1:0];

  always_comb begin
    if (&expo) begin
      if (frac == '0)          cls = CLS_INF;
      else if (frac[FRAC_W-1]) cls = CLS_QNAN;
      else                     cls = CLS_SNAN;
    end else if (expo == '0) begin
      cls = (frac == '0) ? CLS_ZERO : CLS_SUB;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    op_min,
  input  logic [EXP_W+FRAC_W:0]   a,
  input  logic [EXP_W+FRAC_W:0]   b,
  input  fp_class_e               cls_a,
  input  fp_class_e               cls_b,
  input  logic                    sign_a,
  input  logic                    sign_b,
  input  logic [EXP_W+FRAC_W-1:0] mag_a,
  input  logic [EXP_W+FRAC_W-1:0] mag_b,
  output logic [EXP_W+FRAC_W:0]   res,
  output logic                    flag_snan,
  output logic                    flag_inf
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_gt;
  logic take_a;

  // exponent sits above fraction, so one unsigned compare orders magnitudes
  assign a_gt   = mag_a > mag_b;
  // same sign: max keeps the larger value, min the smaller
  assign take_a = a_gt ^ sign_a ^ op_min;

  always_comb begin
    res       = b;
    flag_snan = 1'b0;
    flag_inf  = 1'b0;
    if (cls_a == CLS_SNAN) begin
      res       = a | QBIT;
      flag_snan = 1'b1;
    end else if (cls_b == CLS_SNAN) begin
      res       = b | QBIT;
      flag_snan = 1'b1;
    end else if (cls_a == CLS_QNAN) begin
      res = a;
    end else if (cls_b == CLS_QNAN) begin
      res = b;
    end else if (cls_a == CLS_INF) begin
      if (cls_b == CLS_INF && sign_a == sign_b) begin
        res      = DFLT_NAN;
        flag_inf = 1'b1;
      end else begin
        res = (sign_a ^ op_min) ? b : a;
      end
    end else if (cls_b == CLS_INF) begin
      res = (sign_b ^ op_min) ? a : b;
    end else if (sign_a != sign_b) begin
      res = (sign_a ^ op_min) ? b : a;
    end else begin
      res = take_a ? a : b;
    end
  end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter bit USE_BINARY64 = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic                                 op_sel,
  input  logic [(USE_BINARY64 ? 64 : 32)-1:0]  a,
  input  logic [(USE_BINARY64 ? 64 : 32)-1:0]  b,
  output logic                                 out_valid,
  output logic [(USE_BINARY64 ? 64 : 32)-1:0]  result,
  output logic                                 invalid_snan,
  output logic                                 invalid_inf
);
  localparam int EXP_W  = USE_BINARY64 ? 11 : 8;
  localparam int FRAC_W = USE_BINARY64 ? 52 : 23;
  localparam int W      = 1 + EXP_W + FRAC_W;

  logic [W-1:0]   opnd [2];
  fp_class_e      cls  [2];
  logic           sgn  [2];
  logic [W-2:0]   mag  [2];

  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .operand (opnd[i]),
      .cls     (cls[i]),
      .sign    (sgn[i]),
      .mag     (mag[i])
    );
  end

  logic [W-1:0] pick_res;
  logic         pick_snan;
  logic         pick_inf;

  fpmm_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
    .op_min    (op_sel),
    .a         (a),
    .b         (b),
    .cls_a     (cls[0]),
    .cls_b     (cls[1]),
    .sign_a    (sgn[0]),
    .sign_b    (sgn[1]),
    .mag_a     (mag[0]),
    .mag_b     (mag[1]),
    .res       (pick_res),
    .flag_snan (pick_snan),
    .flag_inf  (pick_inf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      invalid_snan <= 1'b0;
      invalid_inf  <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      invalid_snan <= in_valid & pick_snan;
      invalid_inf  <= in_valid & pick_inf;
      if (in_valid) result <= pick_res;
    end
  end
endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker #(
  parameter int W      = 32,
  parameter int FRAC_W = 23
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         invalid_snan,
  input logic         invalid_inf
);
  localparam int EXP_W = W - 1 - FRAC_W;
  localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_sig, b_sig, res_sig;
  assign a_sig   = (&a[W-2:FRAC_W]) && !a[FRAC_W-1] && (a[FRAC_W-2:0] != '0);
  assign b_sig   = (&b[W-2:FRAC_W]) && !b[FRAC_W-1] && (b[FRAC_W-2:0] != '0);
  assign res_sig = (&result[W-2:FRAC_W]) && !result[FRAC_W-1] && (result[FRAC_W-2:0] != '0);

  // R1: left signalling NaN wins and is quieted
  a_r1_left_snan: assert property (@(posedge clk) disable iff (rst)
    in_valid && a_sig |=> invalid_snan && result == ($past(a) | QBIT));

  // R2: right signalling NaN is quieted when left is not signalling
  a_r2_right_snan: assert property (@(posedge clk) disable iff (rst)
    in_valid && !a_sig && b_sig |=> invalid_snan && result == ($past(b) | QBIT));

  // R4: invalid infinity always comes with the default NaN
  a_r4_inf_dflt: assert property (@(posedge clk) disable iff (rst)
    invalid_inf |-> result == DFLT_NAN && !invalid_snan);

  // R8: valid travels with one cycle of latency
  a_r8_valid_lat: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_idle_lat: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9: idle cycles hold the result and clear status
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && !invalid_snan && !invalid_inf);

  // R1: a delivered result is never a signalling NaN
  a_r1_never_sig: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !res_sig);
endmodule

bind fpmm_unit fpmm_checker #(.W(W), .FRAC_W(FRAC_W)) u_fpmm_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .a            (a),
  .b            (b),
  .out_valid    (out_valid),
  .result       (result),
  .invalid_snan (invalid_snan),
  .invalid_inf  (invalid_inf)
);

// File: tb/fpmm_unit_bench.sv
module fpmm_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sel = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        invalid_snan;
  logic        invalid_inf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fpmm_unit #(.USE_BINARY64(1'b0)) u_fpmm_unit (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .op_sel       (op_sel),
    .a            (a),
    .b            (b),
    .out_valid    (out_valid),
    .result       (result),
    .invalid_snan (invalid_snan),
    .invalid_inf  (invalid_inf)
  );

  logic [31:0] vals [20];
  initial begin
    vals[0]  = 32'h0000_0000; vals[1]  = 32'h8000_0000;
    vals[2]  = 32'h0000_0001; vals[3]  = 32'h8000_0001;
    vals[4]  = 32'h007F_FFFF; vals[5]  = 32'h807F_FFFF;
    vals[6]  = 32'h3F80_0000; vals[7]  = 32'hBF80_0000;
    vals[8]  = 32'h3FC0_0000; vals[9]  = 32'hBFC0_0000;
    vals[10] = 32'h7F7F_FFFF; vals[11] = 32'hFF7F_FFFF;
    vals[12] = 32'h7F80_0000; vals[13] = 32'hFF80_0000;
    vals[14] = 32'h7FC0_0123; vals[15] = 32'hFFC0_0456;
    vals[16] = 32'h7F80_0011; vals[17] = 32'hFF80_0022;
    vals[18] = 32'h4000_0000; vals[19] = 32'h3F80_0001;
  end

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit is_inf(input logic [31:0] x);
    return x[30:0] == 31'h7F80_0000;
  endfunction

  // total order key: -max .. -0 < +0 .. +max
  function automatic logic [31:0] okey(input logic [31:0] x);
    return x[31] ? (32'h7FFF_FFFF - {1'b0, x[30:0]}) : (32'h8000_0000 + {1'b0, x[30:0]});
  endfunction

  task automatic model(input bit mn, input logic [31:0] x, input logic [31:0] y,
                       output logic [31:0] r, output bit fs, output bit fi,
                       output string tag);
    fs = 1'b0; fi = 1'b0;
    if (is_nan(x) && !x[22])      begin r = x | 32'h0040_0000; fs = 1'b1; tag = "R1"; end
    else if (is_nan(y) && !y[22]) begin r = y | 32'h0040_0000; fs = 1'b1; tag = "R2"; end
    else if (is_nan(x))           begin r = x; tag = "R3"; end
    else if (is_nan(y))           begin r = y; tag = "R3"; end
    else if (is_inf(x) && is_inf(y) && x[31] == y[31]) begin
      r = 32'h7FC0_0000; fi = 1'b1; tag = "R4";
    end else begin
      if (is_inf(x) || is_inf(y)) tag = "R5";
      else if (x[31] != y[31])    tag = "R6";
      else                        tag = "R7";
      if (mn) r = (okey(x) <= okey(y)) ? x : y;
      else    r = (okey(x) >= okey(y)) ? x : y;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] er;
    bit ef, ei;
    string tg;
    logic [31:0] last;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", {31'b0, out_valid}, 32'd0, "out_valid in reset");
    check("R8", result, 32'd0, "result in reset");
    check("R8", {30'b0, invalid_snan, invalid_inf}, 32'd0, "status in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R8", {31'b0, out_valid}, 32'd0, "out_valid idle after reset");
    for (int op = 0; op < 2; op++) begin
      for (int i = 0; i < 20; i++) begin
        for (int j = 0; j < 20; j++) begin
          in_valid = 1'b1; op_sel = op[0]; a = vals[i]; b = vals[j];
          model(op[0], vals[i], vals[j], er, ef, ei, tg);
          @(negedge clk);
          check(tg, result, er, $sformatf("result op=%0d a=%h b=%h", op, vals[i], vals[j]));
          check(tg, {30'b0, invalid_snan, invalid_inf}, {30'b0, ef, ei}, "status");
          check("R8", {31'b0, out_valid}, 32'd1, "out_valid after valid");
        end
      end
    end
    // R9: idle after a flagged result holds value and clears status
    in_valid = 1'b1; op_sel = 1'b0; a = 32'hFF80_0000; b = 32'hFF80_0000;
    @(negedge clk);
    last = result;
    check("R4", last, 32'h7FC0_0000, "default NaN before idle");
    in_valid = 1'b0; a = 32'h3F80_0000; b = 32'h7F80_0011;
    @(negedge clk);
    check("R9", result, last, "result held while idle");
    check("R9", {30'b0, invalid_snan, invalid_inf}, 32'd0, "status cleared while idle");
    check("R8", {31'b0, out_valid}, 32'd0, "out_valid low after idle");
    @(negedge clk);
    check("R9", result, last, "result held second idle cycle");
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule